// File: doc/BRIEF.md
# Odd-Ratio Clock Divider with Even Duty Cycle

This block divides an input clock by an odd ratio, five by default, so a 50 MHz input yields a 10 MHz output. The main output is high for exactly half of each output period. An odd ratio puts half a period at a fractional input cycle, so the output must switch on both input edges. A single counter runs on the rising edge and decodes a registered "early half" level. One falling-edge flop takes a half-cycle-delayed copy of that level. The output is the OR of the two. Because the falling-edge flop only retimes a rising-edge signal, the phase between the two halves is the same after every reset.

A second output gives the rising-edge-only alternative. It is a registered level that is high for (N-1)/2 of the N input cycles, which is 2 of 5 for the default ratio. Logic in the input clock domain can use it as a qualifying enable. The raw reset is active low. It may assert at any time. A two-stage synchronizer releases it into the counter and the falling-edge flop, so the first output edge lands on a fixed input cycle after release.

Top module: `fdiv_odd50`

## Requirements
- R1: Once running, `div_half_o` has a period of exactly DIV_RATIO input clock cycles (50 ns at the default ratio and a 10 ns input clock).
- R2: In every output period, `div_half_o` is high for exactly DIV_RATIO input half-cycles and then low for DIV_RATIO input half-cycles (25 ns high and 25 ns low by default).
- R3: `div_twofive_o` changes only on rising input edges. It is high for the first (DIV_RATIO-1)/2 input cycles of each output period (2 of 5 by default) and rises on the same rising edge as `div_half_o`.
- R4: While `arst_n_i` is low, both outputs are low. After `arst_n_i` falls, both outputs are low no later than the first falling input edge that follows the next rising input edge.
- R5: If `arst_n_i` rises between two rising input edges, both outputs stay low through the first two rising edges after the release and first go high on the third. The result is the same for any release point within the input low phase.
- R6: `div_half_o` rises only together with a rising input edge and falls only together with a falling input edge.
- R7: DIV_RATIO must be odd and at least 3; any other value stops elaboration. The counter width is derived from DIV_RATIO.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock to be divided |
| arst_n_i | input | 1 | Raw active-low reset; asserts asynchronously and is released through the internal synchronizer |
| div_half_o | output | 1 | Divided clock, high for DIV_RATIO input half-cycles in each output period |
| div_twofive_o | output | 1 | Registered level, high for (DIV_RATIO-1)/2 input cycles in each output period |

## Verification
A counter that wraps at the wrong value, or starts from the wrong value after reset, changes the output period or moves the first high phase. The period check shows this within one output period. It also appears as a mismatch at the first sampled half-cycle after the third rising edge. A falling-edge flop that captures the wrong level, or on the wrong edge, changes the high time from 25 ns. The next measured pulse shows this. A synchronizer with too few or too many stages shifts the first rising output edge by a whole input cycle. The scoreboard sees this at the first output half-cycle after release.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
// Shared helpers for the odd-ratio divider.
// Assumes the ratio has already been checked to be odd and at least 3.
package fdiv_pkg;

    // Bits needed to hold counts 0 .. ratio-1.
    function automatic int cnt_width(input int ratio);
        int w;
        w = $clog2(ratio);
        return (w < 1) ? 1 : w;
    endfunction

    // Number of full input cycles in the registered early-half level.
    function automatic int early_cycles(input int ratio);
        return (ratio - 1) / 2;
    endfunction

endpackage

// File: rtl/fdiv_rst_sync.sv
`timescale 1ns/1ps
// Reset synchronizer: assertion passes straight through asynchronously,
// release is delayed by STAGES rising edges of clk_i.
// Assumes STAGES >= 2.
module fdiv_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic rst_n_o
);

    logic [STAGES-1:0] chain_q;

    // Shift ones in after release; clear at once when the raw reset asserts.
    always_ff @(posedge clk_i or negedge arst_n_i) begin
        if (!arst_n_i) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], 1'b1};
        end
    end

    assign rst_n_o = chain_q[STAGES-1];

endmodule

// File: rtl/fdiv_mod_counter.sv
`timescale 1ns/1ps
// Rising-edge modulo counter with a registered early-half decode.
// During reset the count is parked at RATIO-1, so the first active edge
// loads 0 and raises the decode. hi_o is high while the count is below HI_CNT.
// Assumes rst_n_i is already synchronous to clk_i.
module fdiv_mod_counter #(
    parameter int RATIO  = 5,
    parameter int CNT_W  = 3,
    parameter int HI_CNT = 2
) (
    input  logic             clk_i,
    input  logic             rst_n_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hi_o
);

    localparam logic [CNT_W-1:0] LAST   = CNT_W'(RATIO - 1);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HI_CNT);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             hi_q;

    // Next count, wrapping from the last value back to zero.
    always_comb begin
        cnt_d = (cnt_q == LAST) ? '0 : cnt_q + CNT_W'(1);
    end

    // Count and register the decode of the next count, synchronous reset.
    always_ff @(posedge clk_i) begin
        if (!rst_n_i) begin
            cnt_q <= LAST;
            hi_q  <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            hi_q  <= (cnt_d < HI_LIM);
        end
    end

    assign cnt_o = cnt_q;
    assign hi_o  = hi_q;

endmodule

// File: rtl/fdiv_half_shift.sv
`timescale 1ns/1ps
// Half-cycle stretcher: a falling-edge copy of the rising-edge level,
// ORed with it, extends the high time by one input half-cycle.
// Assumes hi_i changes only on rising edges of clk_i.
module fdiv_half_shift (
    input  logic clk_i,
    input  logic rst_n_i,
    input  logic hi_i,
    output logic neg_o,
    output logic div_o
);

    logic neg_q;

    // Retime the rising-edge level onto the falling edge, synchronous reset.
    always_ff @(negedge clk_i) begin
        if (!rst_n_i) begin
            neg_q <= 1'b0;
        end else begin
            neg_q <= hi_i;
        end
    end

    assign neg_o = neg_q;
    assign div_o = hi_i | neg_q;

endmodule

// File: rtl/fdiv_odd50.sv
`timescale 1ns/1ps
// Odd-ratio divider with a 50% duty output and a 2-of-5 style enable.
// Structure: reset synchronizer -> rising-edge counter -> falling-edge
// stretcher. Assumes DIV_RATIO is odd and >= 3, and that div_half_o is
// not fed back as a clock into logic on clk_i.
module fdiv_odd50 #(
    parameter int DIV_RATIO  = 5,
    parameter int SYNC_DEPTH = 2
) (
    input  logic clk_i,
    input  logic arst_n_i,
    output logic div_half_o,
    output logic div_twofive_o
);

    localparam int CNT_W  = fdiv_pkg::cnt_width(DIV_RATIO);
    localparam int HI_CNT = fdiv_pkg::early_cycles(DIV_RATIO);

    // R7: reject ratios the half-cycle scheme cannot serve.
    if ((DIV_RATIO < 3) || ((DIV_RATIO % 2) == 0)) begin : g_ratio_bad
        $error("fdiv_odd50: DIV_RATIO must be odd and at least 3");
    end

    logic             rst_n_sync;
    logic [CNT_W-1:0] cnt;
    logic             hi;
    logic             neg_hi;

    fdiv_rst_sync #(
        .STAGES (SYNC_DEPTH)
    ) u_rst (
        .clk_i    (clk_i),
        .arst_n_i (arst_n_i),
        .rst_n_o  (rst_n_sync)
    );

    fdiv_mod_counter #(
        .RATIO  (DIV_RATIO),
        .CNT_W  (CNT_W),
        .HI_CNT (HI_CNT)
    ) u_cnt (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_sync),
        .cnt_o   (cnt),
        .hi_o    (hi)
    );

    fdiv_half_shift u_shift (
        .clk_i   (clk_i),
        .rst_n_i (rst_n_sync),
        .hi_i    (hi),
        .neg_o   (neg_hi),
        .div_o   (div_half_o)
    );

    assign div_twofive_o = hi;

endmodule

// File: rtl/fdiv_odd50_chk.sv
`timescale 1ns/1ps
// Property checker for fdiv_odd50, attached with bind below.
// Observes the synchronized reset, the count and both edge-domain levels.
module fdiv_odd50_chk #(
    parameter int RATIO  = 5,
    parameter int CNT_W  = 3,
    parameter int HI_CNT = 2
) (
    input logic             clk_i,
    input logic             arst_n_i,
    input logic             rst_n_sync,
    input logic [CNT_W-1:0] cnt,
    input logic             hi,
    input logic             neg_hi,
    input logic             div_half_o,
    input logic             div_twofive_o
);

    localparam logic [CNT_W-1:0] LAST   = CNT_W'(RATIO - 1);
    localparam logic [CNT_W-1:0] HI_LIM = CNT_W'(HI_CNT);

    // R1
    cnt_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        (cnt == LAST) |=> (cnt == '0));

    // R1
    cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        (cnt <= LAST));

    // R3
    twofive_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_n_sync)
        (div_twofive_o == (cnt < HI_LIM)));

    // R2
    neg_follow_chk: assert property (@(negedge clk_i) disable iff (!rst_n_sync)
        (neg_hi == $past(hi)));

    // R4
    release_low_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        $rose(rst_n_sync) |-> (!div_half_o && !div_twofive_o));

    // R5
    first_edge_chk: assert property (@(posedge clk_i) disable iff (!arst_n_i)
        $rose(rst_n_sync) |=> (div_half_o && div_twofive_o));

endmodule

bind fdiv_odd50 fdiv_odd50_chk #(
    .RATIO  (DIV_RATIO),
    .CNT_W  (CNT_W),
    .HI_CNT (HI_CNT)
) u_chk (
    .clk_i         (clk_i),
    .arst_n_i      (arst_n_i),
    .rst_n_sync    (rst_n_sync),
    .cnt           (cnt),
    .hi            (hi),
    .neg_hi        (neg_hi),
    .div_half_o    (div_half_o),
    .div_twofive_o (div_twofive_o)
);

// File: tb/sim_fdiv_odd50.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver task queues the expected level of both outputs
// for each input half-cycle, and a monitor pops and compares them.
module sim_fdiv_odd50;

    localparam int N = 5;

    logic clk = 1'b0;
    logic arst_n = 1'b0;
    logic div_half;
    logic div_twofive;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic half;
        logic tick;
        logic pre;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    fdiv_odd50 #(.DIV_RATIO(N)) u0 (
        .clk_i         (clk),
        .arst_n_i      (arst_n),
        .div_half_o    (div_half),
        .div_twofive_o (div_twofive)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Driver: four low half-cycles (R5), then `periods` output periods.
    task automatic push_pattern(input int periods);
        for (int i = 0; i < 4; i++) q.push_back('{1'b0, 1'b0, 1'b1});
        for (int p = 0; p < periods; p++) begin
            for (int k = 0; k < 2 * N; k++) begin
                q.push_back('{logic'(k < N), logic'(k < N - 1), 1'b0});
            end
        end
    endtask

    task automatic compare_one();
        exp_t e;
        e = q.pop_front();
        if (e.pre) begin
            chk(div_half == e.half, "R5", "div_half before first edge", int'(div_half), int'(e.half));
            chk(div_twofive == e.tick, "R5", "div_twofive before first edge", int'(div_twofive), int'(e.tick));
        end else begin
            chk(div_half == e.half, "R2", "div_half half-cycle level", int'(div_half), int'(e.half));
            chk(div_twofive == e.tick, "R3", "div_twofive half-cycle level", int'(div_twofive), int'(e.tick));
        end
    endtask

    // Monitor: sample 2 ns after each clock edge.
    task automatic run_monitor();
        while (q.size() > 0) begin
            @(posedge clk); #2; compare_one();
            @(negedge clk); #2; compare_one();
        end
    endtask

    // Release reset `offset` ns after a falling edge, then score the output.
    task automatic release_and_score(input int offset, input int periods);
        @(negedge clk);
        #(offset);
        arst_n = 1'b1;
        push_pattern(periods);
        run_monitor();
    endtask

    // Measure one pulse of div_half (R1, R2, R6).
    task automatic measure_pulse();
        realtime t0, t1, t2;
        @(posedge div_half); t0 = $realtime;
        chk(clk == 1'b1, "R6", "clk level at div_half rise", int'(clk), 1);
        @(negedge div_half); t1 = $realtime;
        chk(clk == 1'b0, "R6", "clk level at div_half fall", int'(clk), 0);
        @(posedge div_half); t2 = $realtime;
        chk((t1 - t0) == 25.0, "R2", "high time ns", int'(t1 - t0), 25);
        chk((t2 - t0) == 50.0, "R1", "period ns", int'(t2 - t0), 50);
    endtask

    // Assert the raw reset mid-run and check the outputs go and stay low.
    task automatic reset_midrun();
        @(negedge clk); #1;
        arst_n = 1'b0;
        @(negedge clk); #2;
        chk(div_half == 1'b0, "R4", "div_half after reset assert", int'(div_half), 0);
        chk(div_twofive == 1'b0, "R4", "div_twofive after reset assert", int'(div_twofive), 0);
        for (int i = 0; i < 6; i++) begin
            @(posedge clk); #2;
            chk(!div_half && !div_twofive, "R4", "outputs held in reset",
                int'({div_half, div_twofive}), 0);
        end
    endtask

    initial begin : watchdog
        #200000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2;
        chk(div_half == 1'b0, "R4", "div_half in initial reset", int'(div_half), 0);
        chk(div_twofive == 1'b0, "R4", "div_twofive in initial reset", int'(div_twofive), 0);

        release_and_score(1, 4);       // R5 early release in low phase
        for (int i = 0; i < 3; i++) measure_pulse();

        reset_midrun();
        release_and_score(4, 4);       // R5 late release in low phase
        for (int i = 0; i < 3; i++) measure_pulse();

        reset_midrun();
        release_and_score(2, 2);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule